// File: doc/BRIEF.md
# Dual-Clock Reversible Binary Counter

This block is a small binary counter that is driven by two separate count lines instead of one clock with a direction select. A rising edge on the up line advances the count while the down line rests high. A rising edge on the down line retreats the count while the up line rests high. An active-low preset input forces the value of a parallel data bus into the counter. An active-high clear input forces the counter to zero and takes priority over the preset and over both count lines.

Two active-low terminal outputs let several stages be chained. The carry output copies the up line while the count sits at its maximum. The borrow output copies the down line while the count sits at zero. Each one can therefore act as the count line of the next stage.

All four control lines are asynchronous to a free-running system clock. Each one passes through a two-flop synchronizer, and count events come from comparing each synchronized sample with the one taken on the cycle before. The block holds its count when the two count lines are in a combination that makes no sense. In that case it raises a sticky flag, which only a clear removes.

Top module: `dual_clock_counter`

## Requirements
- R1: A synchronized rising edge on `up_clk` while `dn_clk` is high adds one to `q`. The count wraps modulo 2^WIDTH, so the maximum value goes to 0.
- R2: A synchronized rising edge on `dn_clk` while `up_clk` is high subtracts one from `q`. The count wraps, so 0 goes to the maximum value.
- R3: `carry_n` is low exactly when `q` is all ones and the synchronized `up_clk` is low. Otherwise it is high.
- R4: `borrow_n` is low exactly when `q` is zero and the synchronized `dn_clk` is low. Otherwise it is high.
- R5: While the synchronized `load_n` is low and `clear` is low, `q` takes `din` on every system clock. Count-line edges in that time have no effect.
- R6: While the synchronized `clear` is high, `q` is zero, whatever the state of `load_n`, `din` and the count lines.
- R7: A count line that is held low through a preset or a clear and after its release is counted on its next rising edge.
- R8: If both synchronized count lines are low, or both rise in the same system cycle, `q` holds and `illegal_seen` becomes 1.
- R9: `illegal_seen` stays at 1 through later legal counting. A synchronized clear returns it to 0.
- R10: A change on a control line reaches `q` on the third rising edge of `clk` after that change. The path is two synchronizer stages plus the count register.
- R11: While `rst_n` is low, `q` is 0, `carry_n` and `borrow_n` are 1, and `illegal_seen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples all control lines |
| rst_n | input | 1 | Asynchronous active-low system reset |
| up_clk | input | 1 | Count-up line; its rising edge advances the count |
| dn_clk | input | 1 | Count-down line; its rising edge retreats the count |
| load_n | input | 1 | Active-low preset; while low, the count follows `din` |
| clear | input | 1 | Active-high master clear; forces zero and clears the flag |
| din | input | WIDTH | Parallel preset data |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry; copy of `up_clk` while the count is at its maximum |
| borrow_n | output | 1 | Active-low borrow; copy of `dn_clk` while the count is zero |
| illegal_seen | output | 1 | Sticky flag for an illegal count-line combination |

## Verification
The hardest situation to reach from the ports is the release case. One count line is held low across a whole preset window, and its first rising edge after the preset is lifted must be counted. The stimulus drops `up_clk`, then opens and closes a preset while `up_clk` stays low, and only after that raises it. Overlapping count-line faults are also forced: both lines are driven low together, and then both are released in the same cycle. Both are checked against a reference model that steps cycle by cycle and tracks the synchronizer delay on its own.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  // Control lines as seen after synchronization.
  typedef struct packed {
    logic up;
    logic dn;
    logic load_n;
    logic clear;
  } ctl_t;

  // Idle levels: both count lines high, no preset, no clear.
  localparam ctl_t CTL_IDLE = '{up: 1'b1, dn: 1'b1, load_n: 1'b1, clear: 1'b0};

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_INC,
    ACT_DEC,
    ACT_LOAD,
    ACT_CLEAR
  } act_t;

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int         STAGES = 2,
  parameter int         W      = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dcc_event.sv
module dcc_event
  import dcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t now,
  output logic up_rise,
  output logic dn_rise,
  output logic up_evt,
  output logic dn_evt,
  output logic illegal
);

  logic up_prev;
  logic dn_prev;

  // The previous samples keep tracking during preset and clear, so a line
  // that stays low releases cleanly on its next rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_prev <= CTL_IDLE.up;
      dn_prev <= CTL_IDLE.dn;
    end else begin
      up_prev <= now.up;
      dn_prev <= now.dn;
    end
  end

  always_comb begin
    up_rise = now.up & ~up_prev;
    dn_rise = now.dn & ~dn_prev;
    illegal = (~now.up & ~now.dn) | (up_rise & dn_rise);
    up_evt  = up_rise & now.dn & ~illegal;
    dn_evt  = dn_rise & now.up & ~illegal;
  end

endmodule

// File: rtl/dcc_core.sv
module dcc_core
  import dcc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             now,
  input  logic [WIDTH-1:0] din,
  input  logic             up_evt,
  input  logic             dn_evt,
  input  logic             illegal,
  output logic [WIDTH-1:0] cnt,
  output logic             err,
  output act_t             act
);

  function automatic logic [WIDTH-1:0] wrap_step(input logic [WIDTH-1:0] v,
                                                 input logic down);
    return down ? v - 1'b1 : v + 1'b1;
  endfunction

  always_comb begin
    if (now.clear)        act = ACT_CLEAR;
    else if (!now.load_n) act = ACT_LOAD;
    else if (up_evt)      act = ACT_INC;
    else if (dn_evt)      act = ACT_DEC;
    else                  act = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case (act)
        ACT_CLEAR: cnt <= '0;
        ACT_LOAD:  cnt <= din;
        ACT_INC:   cnt <= wrap_step(cnt, 1'b0);
        ACT_DEC:   cnt <= wrap_step(cnt, 1'b1);
        default:   cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err <= 1'b0;
    else if (now.clear) err <= 1'b0;
    else if (illegal)   err <= 1'b1;
  end

endmodule

// File: rtl/dcc_terminal.sv
module dcc_terminal #(
  parameter int             WIDTH = 4,
  parameter logic [WIDTH-1:0] TERM = '0
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             line,
  output logic             term_n
);

  // Copies the count line while the count sits on its terminal value.
  assign term_n = ~((cnt == TERM) & ~line);

endmodule

// File: rtl/dual_clock_counter.sv
module dual_clock_counter
  import dcc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_clk,
  input  logic             dn_clk,
  input  logic             load_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             illegal_seen
);

  localparam int               CTL_W   = $bits(ctl_t);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_MIN = '0;

  ctl_t ctl_raw;
  ctl_t ctl_s;

  // Internal events, named so the checker can see them.
  logic             sync_up;
  logic             sync_dn;
  logic             sync_load_n;
  logic             sync_clear;
  logic             up_rise;
  logic             dn_rise;
  logic             up_evt;
  logic             dn_evt;
  logic             illegal_now;
  logic [WIDTH-1:0] cnt;
  logic             err;
  act_t             act;

  assign ctl_raw = '{up: up_clk, dn: dn_clk, load_n: load_n, clear: clear};

  dcc_sync #(
    .STAGES (SYNC_STAGES),
    .W      (CTL_W),
    .INIT   (CTL_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  assign sync_up     = ctl_s.up;
  assign sync_dn     = ctl_s.dn;
  assign sync_load_n = ctl_s.load_n;
  assign sync_clear  = ctl_s.clear;

  dcc_event u_event (
    .clk     (clk),
    .rst_n   (rst_n),
    .now     (ctl_s),
    .up_rise (up_rise),
    .dn_rise (dn_rise),
    .up_evt  (up_evt),
    .dn_evt  (dn_evt),
    .illegal (illegal_now)
  );

  dcc_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .now     (ctl_s),
    .din     (din),
    .up_evt  (up_evt),
    .dn_evt  (dn_evt),
    .illegal (illegal_now),
    .cnt     (cnt),
    .err     (err),
    .act     (act)
  );

  dcc_terminal #(.WIDTH(WIDTH), .TERM(CNT_MAX)) u_carry (
    .cnt    (cnt),
    .line   (sync_up),
    .term_n (carry_n)
  );

  dcc_terminal #(.WIDTH(WIDTH), .TERM(CNT_MIN)) u_borrow (
    .cnt    (cnt),
    .line   (sync_dn),
    .term_n (borrow_n)
  );

  assign q            = cnt;
  assign illegal_seen = err;

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_up,
  input logic             sync_dn,
  input logic             sync_load_n,
  input logic             sync_clear,
  input logic             up_evt,
  input logic             dn_evt,
  input logic             illegal_now,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] din,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             illegal_seen
);

  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_evt && !sync_clear && sync_load_n) |=> (q == WIDTH'($past(q) + 1'b1))); // R1

  AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_evt && !sync_clear && sync_load_n) |=> (q == WIDTH'($past(q) - 1'b1))); // R2

  AST_CARRY_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (q == MAXV && !sync_up)); // R3

  AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (q == '0 && !sync_dn)); // R4

  AST_PRESET_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clear && !sync_load_n) |=> (q == $past(din))); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clear |=> (q == '0 && !illegal_seen)); // R6

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_now && !sync_clear && sync_load_n) |=> ($stable(q) && illegal_seen)); // R8

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_evt && dn_evt)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_seen && !sync_clear) |=> illegal_seen); // R9

endmodule

bind dual_clock_counter dcc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_up      (sync_up),
  .sync_dn      (sync_dn),
  .sync_load_n  (sync_load_n),
  .sync_clear   (sync_clear),
  .up_evt       (up_evt),
  .dn_evt       (dn_evt),
  .illegal_now  (illegal_now),
  .q            (q),
  .din          (din),
  .carry_n      (carry_n),
  .borrow_n     (borrow_n),
  .illegal_seen (illegal_seen)
);

// File: tb/dual_clock_counter_test.sv
module dual_clock_counter_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_clk = 1'b1;
  logic         dn_clk = 1'b1;
  logic         load_n = 1'b1;
  logic         clear = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         carry_n;
  logic         borrow_n;
  logic         illegal_seen;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R11";

  always #4 clk = ~clk; // 125 MHz

  dual_clock_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .up_clk(up_clk), .dn_clk(dn_clk),
    .load_n(load_n), .clear(clear), .din(din), .q(q),
    .carry_n(carry_n), .borrow_n(borrow_n), .illegal_seen(illegal_seen)
  );

  // Reference model. The line history stands for the input delay: position 1
  // is the newest sample and position 3 the oldest.
  int m_cnt, m_err;
  int hu[1:3], hd[1:3], hl[1:3], hc[1:3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_err = 0;
      for (int i = 1; i <= 3; i++) begin
        hu[i] = 1; hd[i] = 1; hl[i] = 1; hc[i] = 0;
      end
    end else begin
      int su, sd, ru, rd, bad;
      su = hu[2]; sd = hd[2];
      ru = (su == 1 && hu[3] == 0) ? 1 : 0;
      rd = (sd == 1 && hd[3] == 0) ? 1 : 0;
      bad = ((su == 0 && sd == 0) || (ru == 1 && rd == 1)) ? 1 : 0;
      if (hc[2] == 1) m_cnt = 0;
      else if (hl[2] == 0) m_cnt = int'(din);
      else if (bad == 0 && ru == 1 && sd == 1) m_cnt = (m_cnt + 1) % 16;
      else if (bad == 0 && rd == 1 && su == 1) m_cnt = (m_cnt + 15) % 16;
      if (hc[2] == 1) m_err = 0;
      else if (bad == 1) m_err = 1;
      for (int i = 3; i > 1; i--) begin
        hu[i] = hu[i-1]; hd[i] = hd[i-1]; hl[i] = hl[i-1]; hc[i] = hc[i-1];
      end
      hu[1] = int'(up_clk); hd[1] = int'(dn_clk);
      hl[1] = int'(load_n); hc[1] = int'(clear);
    end
  end

  // Compare against the model once per cycle, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      int ec, eb;
      ec = (m_cnt == 15 && hu[2] == 0) ? 0 : 1;
      eb = (m_cnt == 0 && hd[2] == 0) ? 0 : 1;
      checks++;
      if (int'(q) != m_cnt || int'(carry_n) != ec || int'(borrow_n) != eb ||
          int'(illegal_seen) != m_err) begin
        errors++;
        $display("FAIL %s model: q=%0d c=%0d b=%0d f=%0d expected q=%0d c=%0d b=%0d f=%0d",
                 cur_req, q, carry_n, borrow_n, illegal_seen, m_cnt, ec, eb, m_err);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_up();
    up_clk = 1'b0; wait_n(3); up_clk = 1'b1; wait_n(4);
  endtask

  task automatic pulse_dn();
    dn_clk = 1'b0; wait_n(3); dn_clk = 1'b1; wait_n(4);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R11: reset state
    wait_n(2);
    expect_val("R11", "q in reset", int'(q), 0);
    expect_val("R11", "carry_n in reset", int'(carry_n), 1);
    expect_val("R11", "borrow_n in reset", int'(borrow_n), 1);
    expect_val("R11", "flag in reset", int'(illegal_seen), 0);
    rst_n = 1'b1;
    wait_n(4);

    // R1: count up
    cur_req = "R1";
    for (int i = 0; i < 5; i++) pulse_up();
    expect_val("R1", "after five up edges", int'(q), 5);
    for (int i = 0; i < 10; i++) pulse_up();
    expect_val("R1", "at maximum", int'(q), 15);

    // R3: carry copies the up line at the maximum
    cur_req = "R3";
    up_clk = 1'b0; wait_n(3);
    expect_val("R3", "carry_n at 15 with up low", int'(carry_n), 0);
    cur_req = "R1";
    up_clk = 1'b1; wait_n(4);
    expect_val("R1", "wrap 15 to 0", int'(q), 0);
    expect_val("R3", "carry_n after wrap", int'(carry_n), 1);

    // R4 and R2: borrow at zero, then wrap downward
    cur_req = "R4";
    dn_clk = 1'b0; wait_n(3);
    expect_val("R4", "borrow_n at 0 with down low", int'(borrow_n), 0);
    cur_req = "R2";
    dn_clk = 1'b1; wait_n(4);
    expect_val("R2", "wrap 0 to 15", int'(q), 15);
    for (int i = 0; i < 3; i++) pulse_dn();
    expect_val("R2", "after three down edges", int'(q), 12);

    // R10: the count changes on the third edge after the line rises
    cur_req = "R10";
    up_clk = 1'b0; wait_n(4);
    up_clk = 1'b1;
    wait_n(2);
    expect_val("R10", "q two edges after the rise", int'(q), 12);
    wait_n(1);
    expect_val("R10", "q three edges after the rise", int'(q), 13);
    wait_n(2);

    // R5: the preset follows din and ignores the count lines
    cur_req = "R5";
    din = 4'd9; load_n = 1'b0; wait_n(4);
    expect_val("R5", "preset to 9", int'(q), 9);
    pulse_up();
    expect_val("R5", "up edge during preset ignored", int'(q), 9);
    din = 4'd3; wait_n(2);
    expect_val("R5", "preset follows din", int'(q), 3);
    load_n = 1'b1; wait_n(4);
    expect_val("R5", "value kept after preset", int'(q), 3);

    // R6: clear overrides the preset
    cur_req = "R6";
    din = 4'd7; load_n = 1'b0; clear = 1'b1; wait_n(4);
    expect_val("R6", "clear beats preset", int'(q), 0);
    pulse_dn();
    expect_val("R6", "down edge during clear ignored", int'(q), 0);
    load_n = 1'b1; clear = 1'b0; wait_n(4);
    expect_val("R6", "zero after release", int'(q), 0);

    // R7: a line held low across a preset counts on its next rise
    cur_req = "R7";
    up_clk = 1'b0; wait_n(2);
    din = 4'd6; load_n = 1'b0; wait_n(4);
    load_n = 1'b1; wait_n(4);
    expect_val("R7", "preset value with up still low", int'(q), 6);
    up_clk = 1'b1; wait_n(4);
    expect_val("R7", "first rise after preset counted", int'(q), 7);

    // R8: both lines low, then both rise together
    cur_req = "R8";
    up_clk = 1'b0; dn_clk = 1'b0; wait_n(4);
    expect_val("R8", "flag on both low", int'(illegal_seen), 1);
    expect_val("R8", "hold on both low", int'(q), 7);
    up_clk = 1'b1; dn_clk = 1'b1; wait_n(4);
    expect_val("R8", "hold on simultaneous rises", int'(q), 7);

    // R9: the flag is sticky until a clear
    cur_req = "R9";
    pulse_up();
    expect_val("R9", "counting resumes", int'(q), 8);
    expect_val("R9", "flag still set", int'(illegal_seen), 1);
    clear = 1'b1; wait_n(3); clear = 1'b0; wait_n(4);
    expect_val("R9", "flag cleared", int'(illegal_seen), 0);
    expect_val("R6", "count cleared", int'(q), 0);

    // R3: carry with a preset to the maximum
    cur_req = "R3";
    din = 4'd15; load_n = 1'b0; wait_n(3); load_n = 1'b1; wait_n(3);
    up_clk = 1'b0; wait_n(3);
    expect_val("R3", "carry_n after preset to 15", int'(carry_n), 0);
    up_clk = 1'b1; wait_n(4);
    expect_val("R1", "wrap after preset", int'(q), 0);

    wait_n(2);
    finish_run();
  end

endmodule